// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block holds the coherence state of every line of a small private write-back cache that sits on a shared snooping bus. For each line it keeps one of four states: Modified, Exclusive, Shared or Invalid. The local processor presents read and write requests by line index. The block either completes them as hits, or issues a bus request to obtain the line or to gain ownership of it. While it does so, it watches the transactions that other agents place on the bus. It reacts to them by demoting or invalidating its own copies, by raising a flush strobe when it must supply dirty data, and by raising a shared-hit signal that the requester uses to choose between Exclusive and Shared.

Data arrays, bus arbitration and memory are outside the block. Data movement appears only as two signals. The flush strobe tells the data path to drive the line. The completion input `bus_done`, together with `bus_shared`, tells the block that its own transaction has finished. The bus is assumed to serialise transactions, so a snoop never names the same line as the block's own completion in the same cycle.

Only one processor request can be outstanding. Snoops to other lines keep being serviced while it waits. A pending ownership upgrade that loses a race against another agent's write is turned into a full read-for-ownership.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. The state encoding seen on `cpu_line_state` is Invalid=00, Shared=01, Exclusive=10, Modified=11.
- R2: A read to an Invalid line issues a bus request of kind 01 (read) for that index. When `bus_done` is sampled, the line becomes Exclusive if `bus_shared` is 0 and Shared if it is 1. `cpu_ack` pulses in the cycle after `bus_done`.
- R3: A write to an Exclusive line completes as a hit with no bus request, the line becomes Modified, and `cpu_ack` pulses in the cycle after acceptance.
- R4: A write to a Shared line issues a bus request of kind 11 (upgrade). When it completes, the line becomes Modified.
- R5: A write to an Invalid line issues a bus request of kind 10 (read-exclusive). When it completes, the line becomes Modified.
- R6: A snooped read (kind 01) to a Modified line raises `snp_flush` and `snp_shared` in the same cycle, and the line becomes Shared.
- R7: A snooped read to an Exclusive line makes it Shared without a flush. `snp_shared` is 1 during a snooped read exactly when the addressed line is not Invalid.
- R8: A snooped read-exclusive or upgrade (kinds 10, 11) makes a Shared or Exclusive line Invalid without a flush. On a Modified line it raises `snp_flush` and the line becomes Invalid.
- R9: Reads to Modified, Exclusive or Shared lines, and writes to Modified lines, complete with no bus request, leave the state unchanged, and pulse `cpu_ack` in the cycle after acceptance.
- R10: A Shared line is never promoted to Exclusive. Local reads leave it Shared.
- R11: While a bus request is outstanding, `cpu_req_ready` is 0 and the request kind and index are held. Snoops to other lines are still applied.
- R12: If a snooped read-exclusive or upgrade names the line of a pending upgrade, the line becomes Invalid and the pending request changes to kind 10 from the next cycle. On completion, the line becomes Modified.
- R13: In a cycle where a valid snoop names the same index as `cpu_req_idx`, `cpu_req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_idx | input | IDX_W | Line index of the processor request |
| cpu_req_ready | output | 1 | Request can be accepted this cycle |
| cpu_ack | output | 1 | One-cycle pulse when a request completes |
| cpu_line_state | output | 2 | Current state of line `cpu_req_idx` |
| breq_valid | output | 1 | Own bus request outstanding |
| breq_kind | output | 2 | 01 read, 10 read-exclusive, 11 upgrade |
| breq_idx | output | IDX_W | Line index of the own bus request |
| bus_done | input | 1 | Own bus transaction completes this cycle |
| bus_shared | input | 1 | Another cache reported a copy (read fills) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_kind | input | 2 | Snooped kind, same code as `breq_kind` |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| snp_shared | output | 1 | Snooped read hits a valid line |
| snp_flush | output | 1 | Snoop hits a Modified line; data must be driven |

## Verification
A wrong state held for a line stays hidden until that line is touched again. It then shows up in one of three ways: the wrong request kind on the bus (or a bus request where a hit was due), a missing or spurious flush or shared-hit in the same cycle as a snoop, or a wrong value on `cpu_line_state` once the line is addressed. The bench therefore follows each transition with an immediate lookup of the line. It also drives the races that corrupt state quietly: a snoop during an outstanding miss, a collision between a snoop and a processor request, and an upgrade that loses to another writer. A lost promotion or a missed invalidation is visible one cycle after the causing event.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_SHD = 2'b01,
        ST_EXC = 2'b10,
        ST_MOD = 2'b11
    } line_state_t;

    typedef enum logic [1:0] {
        BK_NONE = 2'b00,
        BK_RD   = 2'b01,
        BK_RDX  = 2'b10,
        BK_UPG  = 2'b11
    } bus_kind_t;

    typedef struct packed {
        logic        hit;
        line_state_t nxt;
        bus_kind_t   kind;
    } cpu_plan_t;

    // Next state of a line that another agent's transaction names.
    function automatic line_state_t snoop_next(line_state_t cur, bus_kind_t k);
        line_state_t n;
        n = cur;
        case (k)
            BK_RD:          n = (cur == ST_INV) ? ST_INV : ST_SHD;
            BK_RDX, BK_UPG: n = ST_INV;
            default:        n = cur;
        endcase
        return n;
    endfunction

    // Decide whether a processor access hits and, if not, what to ask the bus.
    function automatic cpu_plan_t plan_cpu(line_state_t cur, logic wr);
        cpu_plan_t p;
        if (wr) begin
            p.hit = (cur == ST_MOD) || (cur == ST_EXC);
        end else begin
            p.hit = (cur != ST_INV);
        end
        p.nxt  = (wr && p.hit) ? ST_MOD : cur;
        if (p.hit) begin
            p.kind = BK_NONE;
        end else if (wr) begin
            p.kind = (cur == ST_SHD) ? BK_UPG : BK_RDX;
        end else begin
            p.kind = BK_RD;
        end
        return p;
    endfunction

    // State installed when the own bus transaction completes.
    function automatic line_state_t fill_state(bus_kind_t k, logic others_have);
        line_state_t n;
        if (k == BK_RD) begin
            n = others_have ? ST_SHD : ST_EXC;
        end else begin
            n = ST_MOD;
        end
        return n;
    endfunction

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_cpu_idx,
    output line_state_t      rd_cpu_st,
    input  logic [IDX_W-1:0] rd_snp_idx,
    output line_state_t      rd_snp_st,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  line_state_t      fill_st,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_state_t      snp_st,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_idx,
    input  line_state_t      cpu_st
);

    line_state_t st_q [NUM_LINES];

    // One state register per line; completion of the own transaction wins,
    // then the snoop, then a processor hit.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q[g] <= ST_INV;
                end else if (fill_we && (fill_idx == IDX_W'(g))) begin
                    st_q[g] <= fill_st;
                end else if (snp_we && (snp_idx == IDX_W'(g))) begin
                    st_q[g] <= snp_st;
                end else if (cpu_we && (cpu_idx == IDX_W'(g))) begin
                    st_q[g] <= cpu_st;
                end
            end
        end
    endgenerate

    assign rd_cpu_st = st_q[rd_cpu_idx];
    assign rd_snp_st = st_q[rd_snp_idx];

endmodule

// File: rtl/mesi_snoop_eval.sv
module mesi_snoop_eval
    import mesi_pkg::*;
(
    input  logic        snp_valid,
    input  bus_kind_t   snp_kind,
    input  line_state_t cur_st,
    output logic        upd_we,
    output line_state_t upd_st,
    output logic        hit_shared,
    output logic        need_flush
);

    logic active;

    always_comb begin
        active     = snp_valid && (snp_kind != BK_NONE);
        upd_we     = active;
        upd_st     = snoop_next(cur_st, snp_kind);
        hit_shared = active && (snp_kind == BK_RD) && (cur_st != ST_INV);
        need_flush = active && (cur_st == ST_MOD);
    end

endmodule

// File: rtl/mesi_req_ctrl.sv
module mesi_req_ctrl
    import mesi_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  cpu_plan_t        plan,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             bus_done,
    input  logic             bus_shared,
    input  logic             snp_valid,
    input  bus_kind_t        snp_kind,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             busy,
    output bus_kind_t        pend_kind,
    output logic [IDX_W-1:0] pend_idx,
    output logic             fill_we,
    output line_state_t      fill_st,
    output logic             ack
);

    logic      busy_q;
    bus_kind_t kind_q;
    logic [IDX_W-1:0] idx_q;
    logic      ack_q;
    logic      lost_race;

    // Another writer claims the line while the own upgrade waits: the copy
    // is gone, so the request must now fetch data as well.
    assign lost_race = busy_q && !bus_done && (kind_q == BK_UPG) && snp_valid
                       && (snp_idx == idx_q)
                       && ((snp_kind == BK_RDX) || (snp_kind == BK_UPG));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            kind_q <= BK_NONE;
            idx_q  <= '0;
            ack_q  <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (!busy_q) begin
                if (accept) begin
                    if (plan.hit) begin
                        ack_q <= 1'b1;
                    end else begin
                        busy_q <= 1'b1;
                        kind_q <= plan.kind;
                        idx_q  <= req_idx;
                    end
                end
            end else if (bus_done) begin
                busy_q <= 1'b0;
                kind_q <= BK_NONE;
                ack_q  <= 1'b1;
            end else if (lost_race) begin
                kind_q <= BK_RDX;
            end
        end
    end

    assign busy      = busy_q;
    assign pend_kind = busy_q ? kind_q : BK_NONE;
    assign pend_idx  = idx_q;
    assign fill_we   = busy_q && bus_done;
    assign fill_st   = fill_state(kind_q, bus_shared);
    assign ack       = ack_q;

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_req_valid,
    input  logic             cpu_req_write,
    input  logic [IDX_W-1:0] cpu_req_idx,
    output logic             cpu_req_ready,
    output logic             cpu_ack,
    output logic [1:0]       cpu_line_state,
    output logic             breq_valid,
    output logic [1:0]       breq_kind,
    output logic [IDX_W-1:0] breq_idx,
    input  logic             bus_done,
    input  logic             bus_shared,
    input  logic             snp_valid,
    input  logic [1:0]       snp_kind,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_shared,
    output logic             snp_flush
);

    bus_kind_t   snp_kind_e;
    line_state_t cpu_st;
    line_state_t snp_cur_st;
    line_state_t snp_new_st;
    line_state_t fill_st;
    logic        snp_we;
    logic        fill_we;
    logic        busy;
    logic        collide;
    logic        accept;
    cpu_plan_t   plan;
    bus_kind_t   pend_kind;

    assign snp_kind_e = bus_kind_t'(snp_kind);

    mesi_state_array #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_array (
        .clk        (clk),
        .rst        (rst),
        .rd_cpu_idx (cpu_req_idx),
        .rd_cpu_st  (cpu_st),
        .rd_snp_idx (snp_idx),
        .rd_snp_st  (snp_cur_st),
        .fill_we    (fill_we),
        .fill_idx   (breq_idx),
        .fill_st    (fill_st),
        .snp_we     (snp_we),
        .snp_idx    (snp_idx),
        .snp_st     (snp_new_st),
        .cpu_we     (accept && plan.hit),
        .cpu_idx    (cpu_req_idx),
        .cpu_st     (plan.nxt)
    );

    mesi_snoop_eval u_snoop (
        .snp_valid  (snp_valid),
        .snp_kind   (snp_kind_e),
        .cur_st     (snp_cur_st),
        .upd_we     (snp_we),
        .upd_st     (snp_new_st),
        .hit_shared (snp_shared),
        .need_flush (snp_flush)
    );

    always_comb begin
        plan    = plan_cpu(cpu_st, cpu_req_write);
        collide = snp_valid && (snp_kind_e != BK_NONE) && (snp_idx == cpu_req_idx);
    end

    assign cpu_req_ready = !busy && !collide;
    assign accept        = cpu_req_valid && cpu_req_ready;

    mesi_req_ctrl #(
        .IDX_W (IDX_W)
    ) u_req (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .plan       (plan),
        .req_idx    (cpu_req_idx),
        .bus_done   (bus_done),
        .bus_shared (bus_shared),
        .snp_valid  (snp_valid),
        .snp_kind   (snp_kind_e),
        .snp_idx    (snp_idx),
        .busy       (busy),
        .pend_kind  (pend_kind),
        .pend_idx   (breq_idx),
        .fill_we    (fill_we),
        .fill_st    (fill_st),
        .ack        (cpu_ack)
    );

    assign breq_valid     = busy;
    assign breq_kind      = pend_kind;
    assign cpu_line_state = cpu_st;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req_valid,
    input logic             cpu_req_write,
    input logic [IDX_W-1:0] cpu_req_idx,
    input logic             cpu_req_ready,
    input logic             cpu_ack,
    input logic [1:0]       cpu_line_state,
    input logic             breq_valid,
    input logic [1:0]       breq_kind,
    input logic [IDX_W-1:0] breq_idx,
    input logic             bus_done,
    input logic             snp_valid,
    input logic [1:0]       snp_kind,
    input logic [IDX_W-1:0] snp_idx,
    input logic             snp_shared,
    input logic             snp_flush
);

    logic accept;
    assign accept = cpu_req_valid && cpu_req_ready;

    // R1: first cycle out of reset shows Invalid
    p_reset_inv_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cpu_line_state == 2'b00));

    // R2: read miss raises a read request for the same index
    p_read_miss_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && !cpu_req_write && cpu_line_state == 2'b00)
        |=> (breq_valid && breq_kind == 2'b01 && breq_idx == $past(cpu_req_idx)));

    // R2: completion is acknowledged in the next cycle
    p_done_ack_r2: assert property (@(posedge clk) disable iff (rst)
        (breq_valid && bus_done) |=> (cpu_ack && !breq_valid));

    // R3: write on Exclusive needs no bus
    p_silent_write_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_req_write && cpu_line_state == 2'b10)
        |=> (!breq_valid && cpu_ack));

    // R6: a flush during a snooped read always reports a shared copy
    p_flush_shares_r6: assert property (@(posedge clk) disable iff (rst)
        (snp_flush && snp_kind == 2'b01) |-> snp_shared);

    // R7: no shared report unless a read is snooped
    p_shared_read_r7: assert property (@(posedge clk) disable iff (rst)
        snp_shared |-> (snp_valid && snp_kind == 2'b01));

    // R9: an acknowledge always follows an acceptance or a completion
    p_ack_cause_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> $past(accept || (breq_valid && bus_done)));

    // R11: outstanding request stalls the processor and holds its index
    p_stall_r11: assert property (@(posedge clk) disable iff (rst)
        breq_valid |-> !cpu_req_ready);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (breq_valid && !bus_done) |=> (breq_valid && $stable(breq_idx)));

    // R12: the kind only changes from upgrade to read-exclusive on a lost race
    p_kind_change_r12: assert property (@(posedge clk) disable iff (rst)
        (breq_valid && !bus_done) |=>
        ((breq_kind == $past(breq_kind)) ||
         ($past(breq_kind) == 2'b11 && breq_kind == 2'b10 && $past(snp_valid)
          && $past(snp_idx) == $past(breq_idx) && $past(snp_kind[1]))));

    // R13: same-line snoop blocks the processor in that cycle
    p_collide_r13: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_kind != 2'b00 && snp_idx == cpu_req_idx) |-> !cpu_req_ready);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDX_W(IDX_W)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_write  (cpu_req_write),
    .cpu_req_idx    (cpu_req_idx),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_ack        (cpu_ack),
    .cpu_line_state (cpu_line_state),
    .breq_valid     (breq_valid),
    .breq_kind      (breq_kind),
    .breq_idx       (breq_idx),
    .bus_done       (bus_done),
    .snp_valid      (snp_valid),
    .snp_kind       (snp_kind),
    .snp_idx        (snp_idx),
    .snp_shared     (snp_shared),
    .snp_flush      (snp_flush)
);

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int IW = 4;

    localparam bit [1:0] S_I = 2'b00, S_S = 2'b01, S_E = 2'b10, S_M = 2'b11;
    localparam bit [1:0] K_NONE = 2'b00, K_RD = 2'b01, K_RDX = 2'b10, K_UPG = 2'b11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_write = 1'b0;
    logic [IW-1:0] cpu_req_idx = '0;
    logic          cpu_req_ready;
    logic          cpu_ack;
    logic [1:0]    cpu_line_state;
    logic          breq_valid;
    logic [1:0]    breq_kind;
    logic [IW-1:0] breq_idx;
    logic          bus_done = 1'b0;
    logic          bus_shared = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_kind = 2'b00;
    logic [IW-1:0] snp_idx = '0;
    logic          snp_shared;
    logic          snp_flush;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        int    idx;
        int    st;
        string req;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NL)) i_mesi_line_ctrl (
        .clk            (clk),
        .rst            (rst),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_idx    (cpu_req_idx),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_ack        (cpu_ack),
        .cpu_line_state (cpu_line_state),
        .breq_valid     (breq_valid),
        .breq_kind      (breq_kind),
        .breq_idx       (breq_idx),
        .bus_done       (bus_done),
        .bus_shared     (bus_shared),
        .snp_valid      (snp_valid),
        .snp_kind       (snp_kind),
        .snp_idx        (snp_idx),
        .snp_shared     (snp_shared),
        .snp_flush      (snp_flush)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: every completion pops the expected final state of the line.
    always begin
        @(negedge clk);
        #1;
        if (!rst && cpu_ack) begin
            if (q.size() == 0) begin
                chk(0, "R9", "unexpected completion", 1, 0);
            end else begin
                exp_t it;
                it = q.pop_front();
                chk(int'(cpu_req_idx) == it.idx, it.req, "completed index", int'(cpu_req_idx), it.idx);
                chk(int'(cpu_line_state) == it.st, it.req, "state after completion",
                    int'(cpu_line_state), it.st);
            end
        end
    end

    task automatic cpu_op(bit wr, int idx, bit [1:0] exp_kind, bit sh, bit [1:0] exp_st, string req);
        q.push_back('{idx, int'(exp_st), req});
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_idx   = IW'(idx);
        #1;
        while (!cpu_req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        #1;
        if (exp_kind == K_NONE) begin
            chk(!breq_valid, req, "bus request on hit", int'(breq_valid), 0);
        end else begin
            chk(breq_valid && breq_kind == exp_kind && int'(breq_idx) == idx, req,
                "bus request kind", int'(breq_kind), int'(exp_kind));
            bus_done   = 1'b1;
            bus_shared = sh;
            @(negedge clk);
            bus_done   = 1'b0;
            bus_shared = 1'b0;
        end
    endtask

    task automatic snoop(bit [1:0] k, int idx, bit exp_sh, bit exp_fl, string req);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_kind  = k;
        snp_idx   = IW'(idx);
        #1;
        chk(snp_shared == exp_sh, req, "snoop shared-hit", int'(snp_shared), int'(exp_sh));
        chk(snp_flush == exp_fl, req, "snoop flush", int'(snp_flush), int'(exp_fl));
        @(negedge clk);
        snp_valid = 1'b0;
        snp_kind  = K_NONE;
    endtask

    task automatic peek(int idx, bit [1:0] exp_st, string req);
        @(negedge clk);
        cpu_req_idx = IW'(idx);
        #1;
        chk(cpu_line_state == exp_st, req, "line state", int'(cpu_line_state), int'(exp_st));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        peek(0, S_I, "R1");
        peek(5, S_I, "R1");
        peek(15, S_I, "R1");

        // R2: read misses fill Exclusive or Shared
        cpu_op(0, 1, K_RD, 0, S_E, "R2");
        cpu_op(0, 2, K_RD, 1, S_S, "R2");

        // R3: silent write on Exclusive
        cpu_op(1, 1, K_NONE, 0, S_M, "R3");

        // R9: hits on Modified
        cpu_op(0, 1, K_NONE, 0, S_M, "R9");
        cpu_op(1, 1, K_NONE, 0, S_M, "R9");

        // R10: reads on Shared stay Shared
        cpu_op(0, 2, K_NONE, 0, S_S, "R10");
        cpu_op(0, 2, K_NONE, 0, S_S, "R10");

        // R4: upgrade from Shared
        cpu_op(1, 2, K_UPG, 0, S_M, "R4");

        // R5: read-for-ownership from Invalid
        cpu_op(1, 3, K_RDX, 0, S_M, "R5");

        // R6: snooped read on Modified
        snoop(K_RD, 1, 1, 1, "R6");
        peek(1, S_S, "R6");

        // R7: snooped read on Exclusive, and on Invalid
        cpu_op(0, 4, K_RD, 0, S_E, "R7");
        snoop(K_RD, 4, 1, 0, "R7");
        peek(4, S_S, "R7");
        snoop(K_RD, 9, 0, 0, "R7");
        peek(9, S_I, "R7");

        // R8: invalidating snoops
        snoop(K_RDX, 4, 0, 0, "R8");
        peek(4, S_I, "R8");
        cpu_op(0, 5, K_RD, 0, S_E, "R8");
        snoop(K_UPG, 5, 0, 0, "R8");
        peek(5, S_I, "R8");
        snoop(K_RDX, 3, 0, 1, "R8");
        peek(3, S_I, "R8");

        // R11: outstanding miss stalls, snoop to another line still applied
        q.push_back('{6, int'(S_E), "R11"});
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_idx = IW'(6);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        snp_valid = 1'b1; snp_kind = K_RD; snp_idx = IW'(2);
        #1;
        chk(breq_valid && breq_kind == K_RD && breq_idx == IW'(6), "R11", "miss request",
            int'(breq_kind), int'(K_RD));
        chk(!cpu_req_ready, "R11", "ready while outstanding", int'(cpu_req_ready), 0);
        chk(snp_flush && snp_shared, "R11", "snoop served during miss", int'(snp_flush), 1);
        @(negedge clk);
        snp_valid = 1'b0; snp_kind = K_NONE;
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_idx = IW'(7);
        #1;
        chk(!cpu_req_ready, "R11", "second request stalled", int'(cpu_req_ready), 0);
        chk(breq_valid && breq_idx == IW'(6), "R11", "request held", int'(breq_idx), 6);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        cpu_req_idx = IW'(2);
        #1;
        chk(cpu_line_state == S_S, "R11", "snooped line demoted", int'(cpu_line_state), int'(S_S));
        cpu_req_idx = IW'(6);
        bus_done = 1'b1; bus_shared = 1'b0;
        @(negedge clk);
        bus_done = 1'b0;
        peek(7, S_I, "R11");

        // R12: upgrade loses the race and becomes read-exclusive
        cpu_op(0, 8, K_RD, 1, S_S, "R12");
        q.push_back('{8, int'(S_M), "R12"});
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_idx = IW'(8);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        #1;
        chk(breq_valid && breq_kind == K_UPG, "R12", "initial upgrade", int'(breq_kind), int'(K_UPG));
        snp_valid = 1'b1; snp_kind = K_RDX; snp_idx = IW'(8);
        @(negedge clk);
        snp_valid = 1'b0; snp_kind = K_NONE;
        #1;
        chk(breq_valid && breq_kind == K_RDX, "R12", "reissued kind", int'(breq_kind), int'(K_RDX));
        chk(cpu_line_state == S_I, "R12", "line invalidated", int'(cpu_line_state), int'(S_I));
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;

        // R13: same-line snoop blocks the processor for that cycle
        @(negedge clk);
        cpu_req_idx = IW'(1);
        snp_valid = 1'b1; snp_kind = K_RD; snp_idx = IW'(0);
        #1;
        chk(cpu_req_ready, "R13", "ready with other-line snoop", int'(cpu_req_ready), 1);
        snp_idx = IW'(1);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1;
        #1;
        chk(!cpu_req_ready, "R13", "ready on collision", int'(cpu_req_ready), 0);
        chk(snp_shared, "R13", "shared-hit on collision", int'(snp_shared), 1);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        snp_valid = 1'b0; snp_kind = K_NONE;
        #1;
        chk(!breq_valid && !cpu_ack, "R13", "blocked request not taken", int'(breq_valid), 0);
        cpu_op(0, 1, K_NONE, 0, S_S, "R13");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R9", "missing completions", q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule